// File: doc/BRIEF.md
# TDM Serial Input Capture

This block takes eight serial time-division-multiplexed input lines, each running at 2.048 Mb/s with 32 byte-wide channels in every 125 µs frame, and turns them into parallel bytes written into a 256-entry, 8-bit data memory. All timing comes from one 4.096 MHz clock and an active-low frame pulse. Every bit cell spans two clock cycles. A 512-cycle frame is split into 32 channel slots of 16 cycles each.

A free-running frame counter is forced back to the start of the frame whenever the frame pulse is seen low. Each input line has its own shift register, which samples once per bit cell, most significant bit first. When the last bit of a channel arrives, all eight finished bytes are copied into a holding bank. During the next channel slot they are written to the memory one stream per cycle, at the address formed from the stream and channel numbers. The current channel number, the bit number and a frame-start strobe are exported to the output and control logic that shares this timing.

Top module: `tdm_rx_capture`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the block is at frame cycle 0: `chan_o`=0, `bit_o`=7 and `frame_start_o`=1. `wr_en_o` stays low until a full channel has been received after reset.
- R2: When `fp_ni` is low at a rising clock edge, the next cycle is frame cycle 0. While `fp_ni` is held low, the block stays at cycle 0.
- R3: When `fp_ni` is high, the frame cycle advances by one each clock. After cycle 511 it wraps to cycle 0.
- R4: In frame cycle k (0..511), `chan_o` = k/16 and `bit_o` = 7 - ((k/2) mod 8). Each bit number therefore lasts two cycles.
- R5: `frame_start_o` is high in frame cycle 0 and low in every other cycle.
- R6: Each line is sampled once per bit cell, at the rising edge that ends the first cycle of the cell. The value present in the second cycle of a cell is ignored. The first cell of a channel becomes bit 7 of the stored byte and the last cell becomes bit 0.
- R7: After a channel c completes, the byte of stream s is written in the cycle whose slot position (frame cycle mod 16) equals s, for s = 0..7. The write uses `wr_addr_o` = s*32 + c (stream in bits 7-5, channel in bits 4-0) and `wr_data_o` = the received byte.
- R8: `wr_en_o` is low in slot positions 8 to 15.
- R9: If the frame pulse restarts the frame partway through a channel, that partial channel is never written. The write window keeps carrying the last channel that completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4.096 MHz timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_ni | input | 1 | Active-low frame pulse, sampled on the rising clock edge |
| st_i | input | 8 | Serial input lines, bit n is stream n |
| wr_en_o | output | 1 | Data memory write enable |
| wr_addr_o | output | 8 | Data memory address {stream, channel} |
| wr_data_o | output | 8 | Data memory write byte |
| chan_o | output | 5 | Current channel number |
| bit_o | output | 3 | Current bit number, 7 down to 0 |
| frame_start_o | output | 1 | High in frame cycle 0 |

## Verification
A frame pulse seen at one rising edge shows up on the timing outputs in the very next cycle. The bench keeps its own frame-cycle count, advances it at each edge, and compares it with the outputs at the falling edge in the middle of each cycle. A channel's bytes appear on the write port from 1 to 8 cycles after the edge that captures its bit 0, in slot positions 0 to 7 of the following channel. The bench records what it transmitted at slot position 15 and checks the write port against that record in every cycle. To test the sampling point, the bench drives the inverted bit value in the second cycle of every cell.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned DEF_ST_N  = 8;
  localparam int unsigned DEF_CH_N  = 32;
  localparam int unsigned DEF_BIT_W = 8;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int unsigned CH_N  = tdm_rx_pkg::DEF_CH_N,
  parameter int unsigned BIT_W = tdm_rx_pkg::DEF_BIT_W,
  localparam int unsigned CH_W   = $clog2(CH_N),
  localparam int unsigned BI_W   = $clog2(BIT_W),
  localparam int unsigned SLOT_W = BI_W + 1,
  localparam int unsigned CNT_W  = CH_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_ni,
  output logic [CH_W-1:0]   chan_o,
  output logic [BI_W-1:0]   bit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_start_o,
  output logic              sample_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!fp_ni) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign chan_o        = cnt_q[CNT_W-1:SLOT_W];
  assign slot_o        = cnt_q[SLOT_W-1:0];
  assign bit_o         = BI_W'(BIT_W-1) - cnt_q[SLOT_W-1:1];
  assign frame_start_o = (cnt_q == '0);
  // first half of a bit cell: capture at its closing edge
  assign sample_o      = ~cnt_q[0];

  // R2
  fp_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> frame_start_o);
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_ni && sample_o) |=> ($stable(bit_o) && $stable(chan_o)));
  // R5
  start_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (chan_o == '0 && bit_o == BI_W'(BIT_W-1)));
endmodule

// File: rtl/tdm_deser.sv
module tdm_deser #(
  parameter int unsigned ST_N  = tdm_rx_pkg::DEF_ST_N,
  parameter int unsigned BIT_W = tdm_rx_pkg::DEF_BIT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_i,
  input  logic [ST_N-1:0]            st_i,
  output logic [ST_N-1:0][BIT_W-1:0] bytes_o
);
  for (genvar g = 0; g < ST_N; g++) begin : g_lane
    logic [BIT_W-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= '0;
      else if (sample_i) sh_q <= {sh_q[BIT_W-2:0], st_i[g]};
    end

    assign bytes_o[g] = sh_q;

    // R6
    lane_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_i |=> (sh_q[0] == $past(st_i[g])));
  end
endmodule

// File: rtl/tdm_wr_sched.sv
module tdm_wr_sched #(
  parameter int unsigned ST_N  = tdm_rx_pkg::DEF_ST_N,
  parameter int unsigned CH_N  = tdm_rx_pkg::DEF_CH_N,
  parameter int unsigned BIT_W = tdm_rx_pkg::DEF_BIT_W,
  localparam int unsigned ST_W   = $clog2(ST_N),
  localparam int unsigned CH_W   = $clog2(CH_N),
  localparam int unsigned SLOT_W = $clog2(BIT_W) + 1,
  localparam int unsigned ADDR_W = ST_W + CH_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [CH_W-1:0]            chan_i,
  input  logic [ST_N-1:0][BIT_W-1:0] bytes_i,
  output logic                       wr_en_o,
  output logic [ADDR_W-1:0]          wr_addr_o,
  output logic [BIT_W-1:0]           wr_data_o
);
  logic [ST_N-1:0][BIT_W-1:0] hold_q;
  logic [CH_W-1:0]            hold_ch_q;
  logic                       hold_vld_q;
  logic                       load;
  logic [ST_W-1:0]            idx;

  // last cycle of a channel slot: all lanes hold a full byte
  assign load = &slot_i;
  assign idx  = slot_i[ST_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_ch_q  <= '0;
      hold_vld_q <= 1'b0;
    end else if (load) begin
      hold_q     <= bytes_i;
      hold_ch_q  <= chan_i;
      hold_vld_q <= 1'b1;
    end
  end

  assign wr_en_o   = hold_vld_q && (32'(slot_i) < ST_N);
  assign wr_addr_o = {idx, hold_ch_q};
  assign wr_data_o = hold_q[idx];

  // R7
  win_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> (wr_addr_o[ADDR_W-1 -: ST_W] == '0));
  // R7
  win_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !load && !$past(load)) |=> $stable(hold_ch_q));
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int unsigned ST_N  = tdm_rx_pkg::DEF_ST_N,
  parameter int unsigned CH_N  = tdm_rx_pkg::DEF_CH_N,
  parameter int unsigned BIT_W = tdm_rx_pkg::DEF_BIT_W,
  localparam int unsigned ST_W   = $clog2(ST_N),
  localparam int unsigned CH_W   = $clog2(CH_N),
  localparam int unsigned BI_W   = $clog2(BIT_W),
  localparam int unsigned SLOT_W = BI_W + 1,
  localparam int unsigned ADDR_W = ST_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_ni,
  input  logic [ST_N-1:0]   st_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BIT_W-1:0]  wr_data_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [BI_W-1:0]   bit_o,
  output logic              frame_start_o
);
  logic [SLOT_W-1:0]          slot;
  logic                       sample;
  logic [ST_N-1:0][BIT_W-1:0] bytes;

  tdm_frame_timer #(.CH_N(CH_N), .BIT_W(BIT_W)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fp_ni         (fp_ni),
    .chan_o        (chan_o),
    .bit_o         (bit_o),
    .slot_o        (slot),
    .frame_start_o (frame_start_o),
    .sample_o      (sample)
  );

  tdm_deser #(.ST_N(ST_N), .BIT_W(BIT_W)) u_deser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .st_i     (st_i),
    .bytes_o  (bytes)
  );

  tdm_wr_sched #(.ST_N(ST_N), .CH_N(CH_N), .BIT_W(BIT_W)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_i    (slot),
    .chan_i    (chan_o),
    .bytes_i   (bytes),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: tb/tdm_rx_capture_tb_top.sv
module tdm_rx_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp_n = 1'b1;
  logic [7:0] st = '0;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] chan;
  logic [2:0] bitn;
  logic       fstart;

  tdm_rx_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fp_ni(fp_n), .st_i(st),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .chan_o(chan), .bit_o(bitn), .frame_start_o(fstart)
  );

  always #2 clk = ~clk;

  int   checks = 0;
  int   errors = 0;
  int   kb = 0;
  int   psel = 0;
  int   last_ch = 0;
  bit   any_vld = 1'b0;
  logic [7:0] sent [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, kb, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int sel, input int s, input int c);
    case (sel)
      0:       return 8'(s * 32 + c) ^ 8'h5A;
      1:       return ~8'(c * 8 + s);
      default: return (8'h80 >> ((c + s) % 8)) | 8'(s);
    endcase
  endfunction

  // one clock cycle, entered and left at a falling edge
  task automatic step(input bit fp_low);
    int ch, bp, slot;
    ch   = kb / 16;
    bp   = 7 - ((kb / 2) % 8);
    slot = kb % 16;
    chk(int'(chan) == ch, "R4 chan", int'(chan), ch);
    chk(int'(bitn) == bp, "R4 bit", int'(bitn), bp);
    chk(fstart == (kb == 0), "R5 frame_start", int'(fstart), int'(kb == 0));
    if (slot >= 8) begin
      chk(wr_en == 1'b0, "R8 idle slot", int'(wr_en), 0);
    end else if (!any_vld) begin
      chk(wr_en == 1'b0, "R1 no write before first channel", int'(wr_en), 0);
    end else begin
      chk(wr_en == 1'b1, "R7 write enable", int'(wr_en), 1);
      chk(int'(wr_addr) == slot * 32 + last_ch, "R7 address", int'(wr_addr), slot * 32 + last_ch);
      chk(wr_data == sent[slot * 32 + last_ch], "R6 byte value", int'(wr_data),
          int'(sent[slot * 32 + last_ch]));
    end
    for (int s = 0; s < 8; s++) begin
      logic [7:0] b;
      b = pat(psel, s, ch);
      // second half of a cell carries the inverted bit
      st[s] = (kb % 2 == 0) ? b[bp] : ~b[bp];
    end
    if (slot == 15) begin
      for (int s = 0; s < 8; s++) sent[s * 32 + ch] = pat(psel, s, ch);
      last_ch = ch;
      any_vld = 1'b1;
    end
    fp_n = ~fp_low;
    @(posedge clk);
    kb = fp_low ? 0 : (kb + 1) % 512;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(chan == 5'd0, "R1 chan in reset", int'(chan), 0);
    chk(bitn == 3'd7, "R1 bit in reset", int'(bitn), 7);
    chk(fstart == 1'b1, "R1 frame_start in reset", int'(fstart), 1);
    chk(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    kb = 0;
    any_vld = 1'b0;
  endtask

  task automatic t_free_run;
    psel = 0;
    repeat (300) step(1'b0);
  endtask

  task automatic t_sync_two_frames;
    step(1'b1);
    psel = 0;
    repeat (512) step(1'b0);
    psel = 1; // R3 wrap into the next frame without a pulse
    repeat (512) step(1'b0);
  endtask

  task automatic t_fp_held;
    while (kb != 100) step(1'b0);
    step(1'b1);
    psel = 2; // R2 held low keeps cycle 0
    step(1'b1);
    step(1'b1);
    repeat (600) step(1'b0);
  endtask

  task automatic t_resync_mid;
    while (kb != 200) step(1'b0);
    step(1'b1); // R9 cut channel 12 short
    psel = 0;
    repeat (300) step(1'b0);
  endtask

  task automatic t_async_reset;
    rst_n = 1'b0;
    #1;
    chk(chan == 5'd0, "R1 chan after async reset", int'(chan), 0);
    chk(bitn == 3'd7, "R1 bit after async reset", int'(bitn), 7);
    chk(fstart == 1'b1, "R1 frame_start after async reset", int'(fstart), 1);
    chk(wr_en == 1'b0, "R1 wr_en after async reset", int'(wr_en), 0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    kb = 0;
    any_vld = 1'b0;
    psel = 1;
    repeat (40) step(1'b0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset_state();
    t_free_run();
    t_sync_two_frames();
    t_fp_held();
    t_resync_mid();
    t_async_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule